// File: doc/BRIEF.md
# Cascadable Four-Decade Counter with Overflow Digit

This block counts falling edges on a single count input with four BCD decades and a fifth, one-bit "half digit" that records a decade overflow, so the largest reading is 19999. The count input is treated as a clean digital signal that has already been synchronised to the block clock. The block samples it on every clock and turns a high-to-low change into one count event.

A low level on the inhibit input freezes the first decade without touching the edge detector, so pulses that arrive during the inhibit window are discarded rather than deferred. A low level on the clear input returns every decade and the overflow digit to zero, and it overrides counting. The carry output follows the most significant bit of the top decade. It therefore falls exactly when the top decade wraps from 9 to 0, and that edge can drive the count input of a further block of the same kind. Display decoding, blanking and drive are left to other blocks.

Top module: `halfdec_counter`

## Requirements
- R1: Each high-to-low change of `countIn`, seen between two consecutive clock samples, advances the count by exactly one; a rising change or a steady level does not change the count.
- R2: Each decade holds a BCD value from 0 to 9. A decade wraps from 9 to 0 and, at that same count, advances the next higher decade by one.
- R3: `carryOut` equals bit 3 of the top decade, so it is high while that decade reads 8 or 9. It falls on the count that takes 9999 to 0000.
- R4: `halfDigit` is set by the count that wraps the four decades from 9999 to 0000. Once set, it stays set until a clear or a system reset.
- R5: While `halfDigit` is set, the four decades keep counting normally, and a later 9999-to-0000 wrap again pulls `carryOut` low.
- R6: While `countInhibitN` is low, falling edges of `countIn` are ignored, and every decade and `halfDigit` hold their values.
- R7: While `clearN` is low, all four decades and `halfDigit` are forced to zero at the next clock. This takes priority over counting and over the inhibit.
- R8: After `clearN` returns high, the first falling edge of `countIn` sets the count to 0001.
- R9: A low `rstN` asynchronously sets all decades, `halfDigit` and `carryOut` to zero. A low `countIn` right after reset is not counted as an edge.
- R10: A counted edge shows on the digit outputs right after the clock edge that first samples `countIn` low.

Top module ports are listed below; `digit0` is the least significant decade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| countIn | input | 1 | Count pulse input, synchronised; counts on falling change |
| countInhibitN | input | 1 | Count inhibit, active low (tie high when unused) |
| clearN | input | 1 | Counter clear, active low (tie high when unused) |
| digit0 | output | 4 | Units decade, BCD |
| digit1 | output | 4 | Tens decade, BCD |
| digit2 | output | 4 | Hundreds decade, BCD |
| digit3 | output | 4 | Thousands decade, BCD |
| halfDigit | output | 1 | Sticky overflow digit |
| carryOut | output | 1 | Cascade carry, falls on the 9999-to-0000 wrap |

## Verification
The bench drives a full 9999-to-0000 wrap twice. A half digit that is not sticky, or that fails to set, shows up as a wrong flag on the second pass, and a carry that depends on the flag does not fall again on the second wrap. Pulses under inhibit, and pulses that overlap a clear, go after an inhibit that only delays a count and after a clear that loses its priority; either fault leaves a stray count in the units decade. Rising-only changes and a low count input held across reset release catch an edge detector that counts levels or the wrong polarity. Chained wraps across every decade catch a carry that ripples one decade too early or too late.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  localparam int DIGIT_W   = 4;
  localparam int DIGIT_MAX = 9;

  typedef struct packed {
    logic advance;
    logic clear;
  } hdc_strobes_t;
endpackage

// File: rtl/hdc_control.sv
module hdc_control
  import hdc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         countIn,
  input  logic         countInhibitN,
  input  logic         clearN,
  output hdc_strobes_t strb
);
  logic prevCount;
  logic fallSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevCount <= 1'b0;
    else       prevCount <= countIn;
  end

  assign fallSeen = prevCount & ~countIn;

  always_comb begin
    strb.clear   = ~clearN;
    strb.advance = fallSeen & countInhibitN & clearN;
  end

  AST_ONE_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> !strb.advance); // R1
endmodule

// File: rtl/hdc_datapath.sv
module hdc_datapath
  import hdc_pkg::*;
#(
  parameter int NUM_DECADES = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  hdc_strobes_t                         strb,
  output logic [NUM_DECADES-1:0][DIGIT_W-1:0]  digits,
  output logic                                 halfFlag,
  output logic                                 carryOut
);
  localparam logic [DIGIT_W-1:0] TOP_VAL = DIGIT_W'(DIGIT_MAX);

  logic [NUM_DECADES:0] allNine;
  assign allNine[0] = 1'b1;

  for (genvar g = 0; g < NUM_DECADES; g++) begin : g_decade
    logic [DIGIT_W-1:0] decQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             decQ <= '0;
      else if (strb.clear)                   decQ <= '0;
      else if (strb.advance && allNine[g])   decQ <= (decQ == TOP_VAL) ? '0 : decQ + 1'b1;
    end

    assign digits[g]    = decQ;
    assign allNine[g+1] = allNine[g] & (decQ == TOP_VAL);

    AST_BCD_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
      decQ <= TOP_VAL); // R2
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       halfFlag <= 1'b0;
    else if (strb.clear)                             halfFlag <= 1'b0;
    else if (strb.advance && allNine[NUM_DECADES])   halfFlag <= 1'b1;
  end

  assign carryOut = digits[NUM_DECADES-1][DIGIT_W-1];

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (digits == '0) && !halfFlag); // R7
  AST_HALF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    halfFlag && !strb.clear |=> halfFlag); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance && !strb.clear |=> $stable(digits) && $stable(halfFlag)); // R6
  AST_CARRY_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(carryOut) && !$past(strb.clear) |-> halfFlag && (digits == '0)); // R3
endmodule

// File: rtl/halfdec_counter.sv
module halfdec_counter
  import hdc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       countIn,
  input  logic       countInhibitN,
  input  logic       clearN,
  output logic [3:0] digit0,
  output logic [3:0] digit1,
  output logic [3:0] digit2,
  output logic [3:0] digit3,
  output logic       halfDigit,
  output logic       carryOut
);
  localparam int NUM_DECADES = 4;

  hdc_strobes_t                        strb;
  logic [NUM_DECADES-1:0][DIGIT_W-1:0] digits;

  hdc_control u_control (
    .clk           (clk),
    .rstN          (rstN),
    .countIn       (countIn),
    .countInhibitN (countInhibitN),
    .clearN        (clearN),
    .strb          (strb)
  );

  hdc_datapath #(.NUM_DECADES(NUM_DECADES)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .digits   (digits),
    .halfFlag (halfDigit),
    .carryOut (carryOut)
  );

  assign digit0 = digits[0];
  assign digit1 = digits[1];
  assign digit2 = digits[2];
  assign digit3 = digits[3];
endmodule

// File: tb/halfdec_counter_tb.sv
module halfdec_counter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic countIn = 1'b0;
  logic countInhibitN = 1'b1;
  logic clearN = 1'b1;
  logic [3:0] digit0, digit1, digit2, digit3;
  logic halfDigit, carryOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  halfdec_counter u_dut (
    .clk(clk), .rstN(rstN), .countIn(countIn), .countInhibitN(countInhibitN),
    .clearN(clearN), .digit0(digit0), .digit1(digit1), .digit2(digit2),
    .digit3(digit3), .halfDigit(halfDigit), .carryOut(carryOut)
  );

  // Behavioural reference: a plain integer value and a sticky flag.
  int  mVal = 0;
  bit  mHalf = 0;
  bit  mPrev = 0;
  bit  started = 0;

  always @(posedge clk) begin
    started <= 1;
    if (!rstN) begin
      mVal <= 0; mHalf <= 0; mPrev <= 0;
    end else begin
      if (!clearN) begin
        mVal <= 0; mHalf <= 0;
      end else if (mPrev && !countIn && countInhibitN) begin
        if (mVal == 9999) begin mVal <= 0; mHalf <= 1; end
        else mVal <= mVal + 1;
      end
      mPrev <= countIn;
    end
  end

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int dutVal();
    return digit3 * 1000 + digit2 * 100 + digit1 * 10 + digit0;
  endfunction

  // Per-cycle comparison against the model (R10 timing, R3 carry).
  always @(posedge clk) begin
    #5;
    if (started && !finished) begin
      chk("R10 cycle digits", dutVal(), mVal);
      chk("R4 cycle half", halfDigit, mHalf);
      chk("R3 cycle carry", carryOut, ((mVal / 1000) % 10) >= 8);
    end
  end

  task automatic pulse();
    @(negedge clk) countIn = 1'b1;
    @(negedge clk) countIn = 1'b0;
    @(posedge clk); #5;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) pulse();
  endtask

  initial begin
    countIn = 1'b1;
    repeat (3) @(negedge clk);
    #5;
    chk("R9 reset digits", dutVal(), 0);
    chk("R9 reset half", halfDigit, 0);
    chk("R9 reset carry", carryOut, 0);
    countIn = 1'b0;
    @(negedge clk) rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 low input after reset not counted", dutVal(), 0);

    pulse();
    chk("R1 one falling edge", dutVal(), 1);
    @(negedge clk) countIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 rising edge ignored", dutVal(), 1);
    countIn = 1'b0;
    @(posedge clk); #5;
    chk("R10 count visible after sampling edge", dutVal(), 2);

    pulses(8);
    chk("R2 units wrap", dutVal(), 10);
    chk("R2 tens digit", digit1, 1);
    pulses(989);
    chk("R2 chained wrap", dutVal(), 999);
    pulse();
    chk("R2 ripple to thousands", dutVal(), 1000);

    @(negedge clk) countInhibitN = 1'b0;
    pulses(5);
    chk("R6 inhibit holds", dutVal(), 1000);
    @(negedge clk) countInhibitN = 1'b1;
    @(posedge clk); #5;
    chk("R6 inhibit release no stray count", dutVal(), 1000);

    @(negedge clk) begin clearN = 1'b0; countInhibitN = 1'b0; end
    @(negedge clk) countIn = 1'b1;
    @(negedge clk) countIn = 1'b0;
    @(posedge clk); #5;
    chk("R7 clear wins", dutVal(), 0);
    @(negedge clk) begin clearN = 1'b1; countInhibitN = 1'b1; end
    repeat (2) @(negedge clk);
    chk("R8 no count at release", dutVal(), 0);
    pulse();
    chk("R8 first edge after release", dutVal(), 1);

    pulses(9998);
    chk("R3 carry high at 9999", carryOut, 1);
    chk("R4 half clear before wrap", halfDigit, 0);
    pulse();
    chk("R3 carry fell on wrap", carryOut, 0);
    chk("R4 half set on wrap", halfDigit, 1);
    chk("R4 decades zero after wrap", dutVal(), 0);

    pulses(9999);
    chk("R5 counts with half set", dutVal(), 9999);
    chk("R5 carry high again", carryOut, 1);
    pulse();
    chk("R5 second wrap carry", carryOut, 0);
    chk("R4 half stays set", halfDigit, 1);
    pulses(3);
    chk("R5 keeps counting", dutVal(), 3);

    @(negedge clk) clearN = 1'b0;
    @(negedge clk) clearN = 1'b1;
    #5;
    chk("R7 clear drops half", halfDigit, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule